// File: doc/BRIEF.md
# Integer ALU and Shifter

This is the combinational execute stage of a small 32-bit integer core. From the decoded instruction fields (primary opcode, function code, shift amount, the two register field indices that may name a destination, and the 16-bit immediate) and the two register operand values, it produces the result word. It also decides whether that result may be written back, and into which register index. It covers register-register add, subtract, bitwise logic, signed and unsigned set-less-than, and constant or variable shifts. It also covers the immediate forms of add, logic, set-less-than and load-upper.

Trapping and non-trapping add/subtract differ only in the low bit of the function code. A trapping variant that overflows raises a trap flag and withholds the register write. Unknown encodings raise a separate illegal-instruction flag and also withhold the write. A write aimed at register index 0 is always withheld, because that register reads as zero.

The block has no state. A core places it between operand fetch and the write-back register, and uses the trap and illegal flags to start exception handling.

Top module: `int_exec_unit`

## Requirements
- R1: With opcode 0x00, function codes 0x20/0x21 give `src_a + src_b` and 0x22/0x23 give `src_a - src_b`, both modulo 2^32.
- R2: With opcode 0x00, function codes 0x24, 0x25, 0x26 and 0x27 give bitwise AND, OR, XOR and NOR of `src_a` and `src_b`.
- R3: With opcode 0x00, function code 0x2a gives 1 when `src_a < src_b` as signed numbers and 0 otherwise. Code 0x2b does the same as unsigned numbers. Opcodes 0x0a and 0x0b do the same against the sign-extended immediate.
- R4: With opcode 0x00, function codes 0x00, 0x02 and 0x03 shift `src_b` left logical, right logical and right arithmetic by `shamt`. Codes 0x04, 0x06 and 0x07 do the same by `src_a[4:0]`. Arithmetic right shifts fill with the sign bit.
- R5: Function codes 0x20 and 0x22 and opcode 0x08 raise `ovf_trap` and hold `wr_en` low on signed overflow. Codes 0x21 and 0x23 and opcode 0x09 never raise `ovf_trap`.
- R6: Opcodes 0x08, 0x09, 0x0a and 0x0b sign-extend `imm16`. Opcodes 0x0c, 0x0d and 0x0e AND, OR and XOR `src_a` with the zero-extended `imm16`.
- R7: Opcode 0x0f gives `{imm16, 16'h0000}`.
- R8: `wr_idx` equals `rt_field` for opcodes 0x08 to 0x0f and `rd_field` for opcode 0x00.
- R9: `wr_en` is low whenever `wr_idx` is 0; otherwise it is high for every legal, non-trapping operation.
- R10: Any other opcode, or opcode 0x00 with any other function code, raises `illegal`, holds `wr_en` and `ovf_trap` low, and gives result 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Primary opcode |
| fn_code | input | 6 | Function code for opcode 0 |
| shamt | input | 5 | Constant shift amount |
| rt_field | input | 5 | Second register index, destination of immediate forms |
| rd_field | input | 5 | Destination index of register forms |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm16 | input | 16 | Immediate constant |
| result | output | 32 | Computed value |
| wr_en | output | 1 | Result may be written back |
| wr_idx | output | 5 | Register index to write |
| ovf_trap | output | 1 | Signed overflow on a trapping add/subtract |
| illegal | output | 1 | Unrecognised encoding |

## Verification
Two write-suppression causes can coincide in one evaluation: a trapping overflow and a destination index of 0. The bench provokes this with an overflowing add whose destination field is zero. It expects `ovf_trap` high and `wr_en` low, and an independent model scores it. Signed and unsigned compares run through the shared subtractor. Random operands are biased toward the extreme values, so their disagreement (for example 1 against 0xffffffff) and the overflow boundaries are reached often. These cases are checked against bench functions built on wide arithmetic and the language's own shift operators.

// File: rtl/iex_pkg.sv
`timescale 1ns/1ps
package iex_pkg;
  localparam int OPW = 6;

  localparam logic [OPW-1:0] OPC_REG   = 6'h00;
  localparam logic [OPW-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPW-1:0] OPC_ADDIU = 6'h09;
  localparam logic [OPW-1:0] OPC_SLTI  = 6'h0a;
  localparam logic [OPW-1:0] OPC_SLTIU = 6'h0b;
  localparam logic [OPW-1:0] OPC_ANDI  = 6'h0c;
  localparam logic [OPW-1:0] OPC_ORI   = 6'h0d;
  localparam logic [OPW-1:0] OPC_XORI  = 6'h0e;
  localparam logic [OPW-1:0] OPC_LUI   = 6'h0f;

  localparam logic [OPW-1:0] FN_SLL  = 6'h00;
  localparam logic [OPW-1:0] FN_SRL  = 6'h02;
  localparam logic [OPW-1:0] FN_SRA  = 6'h03;
  localparam logic [OPW-1:0] FN_SLLV = 6'h04;
  localparam logic [OPW-1:0] FN_SRLV = 6'h06;
  localparam logic [OPW-1:0] FN_SRAV = 6'h07;
  localparam logic [OPW-1:0] FN_ADD  = 6'h20;
  localparam logic [OPW-1:0] FN_ADDU = 6'h21;
  localparam logic [OPW-1:0] FN_SUB  = 6'h22;
  localparam logic [OPW-1:0] FN_SUBU = 6'h23;
  localparam logic [OPW-1:0] FN_AND  = 6'h24;
  localparam logic [OPW-1:0] FN_OR   = 6'h25;
  localparam logic [OPW-1:0] FN_XOR  = 6'h26;
  localparam logic [OPW-1:0] FN_NOR  = 6'h27;
  localparam logic [OPW-1:0] FN_SLT  = 6'h2a;
  localparam logic [OPW-1:0] FN_SLTU = 6'h2b;

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR,
    K_SLT, K_SLTU, K_SHL, K_SHR, K_SHA, K_LUI
  } kind_e;

  typedef struct packed {
    logic  legal;
    kind_e kind;
    logic  sub;
    logic  use_imm;
    logic  imm_sext;
    logic  var_amt;
    logic  trap;
    logic  dest_rt;
  } ctrl_t;
endpackage

// File: rtl/iex_decode.sv
`timescale 1ns/1ps
module iex_decode
  import iex_pkg::*;
(
  input  logic [OPW-1:0] op_code,
  input  logic [OPW-1:0] fn_code,
  output ctrl_t          ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.kind = K_ADD;
    if (op_code == OPC_REG) begin
      ctrl.legal = 1'b1;
      unique case (fn_code)
        FN_ADD:  begin ctrl.kind = K_ADD; ctrl.trap = 1'b1; end
        FN_ADDU: ctrl.kind = K_ADD;
        FN_SUB:  begin ctrl.kind = K_SUB; ctrl.sub = 1'b1; ctrl.trap = 1'b1; end
        FN_SUBU: begin ctrl.kind = K_SUB; ctrl.sub = 1'b1; end
        FN_AND:  ctrl.kind = K_AND;
        FN_OR:   ctrl.kind = K_OR;
        FN_XOR:  ctrl.kind = K_XOR;
        FN_NOR:  ctrl.kind = K_NOR;
        FN_SLT:  begin ctrl.kind = K_SLT;  ctrl.sub = 1'b1; end
        FN_SLTU: begin ctrl.kind = K_SLTU; ctrl.sub = 1'b1; end
        FN_SLL:  ctrl.kind = K_SHL;
        FN_SRL:  ctrl.kind = K_SHR;
        FN_SRA:  ctrl.kind = K_SHA;
        FN_SLLV: begin ctrl.kind = K_SHL; ctrl.var_amt = 1'b1; end
        FN_SRLV: begin ctrl.kind = K_SHR; ctrl.var_amt = 1'b1; end
        FN_SRAV: begin ctrl.kind = K_SHA; ctrl.var_amt = 1'b1; end
        default: ctrl.legal = 1'b0;
      endcase
    end else begin
      ctrl.legal    = 1'b1;
      ctrl.use_imm  = 1'b1;
      ctrl.dest_rt  = 1'b1;
      unique case (op_code)
        OPC_ADDI:  begin ctrl.kind = K_ADD; ctrl.imm_sext = 1'b1; ctrl.trap = 1'b1; end
        OPC_ADDIU: begin ctrl.kind = K_ADD; ctrl.imm_sext = 1'b1; end
        OPC_SLTI:  begin ctrl.kind = K_SLT;  ctrl.imm_sext = 1'b1; ctrl.sub = 1'b1; end
        OPC_SLTIU: begin ctrl.kind = K_SLTU; ctrl.imm_sext = 1'b1; ctrl.sub = 1'b1; end
        OPC_ANDI:  ctrl.kind = K_AND;
        OPC_ORI:   ctrl.kind = K_OR;
        OPC_XORI:  ctrl.kind = K_XOR;
        OPC_LUI:   ctrl.kind = K_LUI;
        default: begin
          ctrl.legal   = 1'b0;
          ctrl.use_imm = 1'b0;
          ctrl.dest_rt = 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    // R10
    dec_illegal_quiet_chk: assert (ctrl.legal || (!ctrl.trap && !ctrl.sub))
      else $error("illegal encoding carries operation controls");
  end
endmodule

// File: rtl/iex_addsub.sv
`timescale 1ns/1ps
module iex_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf,
  output logic         lt_s,
  output logic         lt_u
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;
  logic signed [W:0] wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    sum   = full[W-1:0];
    ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    lt_s  = sum[W-1] ^ ovf;
    lt_u  = ~full[W];
  end

  always_comb begin
    wide = sub ? ($signed({a[W-1], a}) - $signed({b[W-1], b}))
               : ($signed({a[W-1], a}) + $signed({b[W-1], b}));
    // R5
    sum_ovf_chk: assert (ovf == (wide[W] != wide[W-1]))
      else $error("overflow flag disagrees with widened result");
    // R3
    cmp_signed_chk: assert (!sub || (lt_s == ($signed(a) < $signed(b))))
      else $error("signed less-than mismatch");
    // R3
    cmp_unsigned_chk: assert (!sub || (lt_u == (a < b)))
      else $error("unsigned less-than mismatch");
  end
endmodule

// File: rtl/iex_shifter.sv
`timescale 1ns/1ps
module iex_shifter #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   data,
  input  logic [SHW-1:0] amt,
  input  logic           left,
  input  logic           arith,
  output logic [W-1:0]   res
);
  logic [W-1:0] rev_in;
  logic [W-1:0] rev_out;
  logic [W-1:0] stage [SHW+1];
  logic         fill;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i] = data[W-1-i];
    assign rev_out[i] = stage[SHW][W-1-i];
  end

  assign fill     = arith & ~left & data[W-1];
  assign stage[0] = left ? rev_in : data;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt[k] ? {{STEP{fill}}, stage[k][W-1:STEP]} : stage[k];
  end

  assign res = left ? rev_out : stage[SHW];

  always_comb begin
    // R4
    sra_sign_chk: assert (!(arith && !left) || (res[W-1] == data[W-1]))
      else $error("arithmetic right shift lost the sign bit");
    // R4
    shl_low_zero_chk: assert (!left || (amt == '0) || (res[0] == 1'b0))
      else $error("left shift did not fill with zero");
  end
endmodule

// File: rtl/int_exec_unit.sv
`timescale 1ns/1ps
module int_exec_unit
  import iex_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16,
  parameter int IDX_W = 5,
  localparam int SHW  = $clog2(W)
) (
  input  logic [OPW-1:0]   op_code,
  input  logic [OPW-1:0]   fn_code,
  input  logic [SHW-1:0]   shamt,
  input  logic [IDX_W-1:0] rt_field,
  input  logic [IDX_W-1:0] rd_field,
  input  logic [W-1:0]     src_a,
  input  logic [W-1:0]     src_b,
  input  logic [IMM_W-1:0] imm16,
  output logic [W-1:0]     result,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             ovf_trap,
  output logic             illegal
);
  ctrl_t        ctrl;
  logic [W-1:0] imm_ext;
  logic [W-1:0] op_b;
  logic [W-1:0] sum;
  logic         ovf, lt_s, lt_u;
  logic [W-1:0] sh_res;
  logic [SHW-1:0] sh_amt;

  iex_decode u_dec (
    .op_code (op_code),
    .fn_code (fn_code),
    .ctrl    (ctrl)
  );

  assign imm_ext = ctrl.imm_sext ? {{(W-IMM_W){imm16[IMM_W-1]}}, imm16}
                                 : {{(W-IMM_W){1'b0}}, imm16};
  assign op_b    = ctrl.use_imm ? imm_ext : src_b;
  assign sh_amt  = ctrl.var_amt ? src_a[SHW-1:0] : shamt;

  iex_addsub #(.W(W)) u_add (
    .a    (src_a),
    .b    (op_b),
    .sub  (ctrl.sub),
    .sum  (sum),
    .ovf  (ovf),
    .lt_s (lt_s),
    .lt_u (lt_u)
  );

  iex_shifter #(.W(W)) u_shf (
    .data  (src_b),
    .amt   (sh_amt),
    .left  (ctrl.kind == K_SHL),
    .arith (ctrl.kind == K_SHA),
    .res   (sh_res)
  );

  always_comb begin
    result = '0;
    if (ctrl.legal) begin
      unique case (ctrl.kind)
        K_ADD, K_SUB: result = sum;
        K_AND:        result = src_a & op_b;
        K_OR:         result = src_a | op_b;
        K_XOR:        result = src_a ^ op_b;
        K_NOR:        result = ~(src_a | op_b);
        K_SLT:        result = {{(W-1){1'b0}}, lt_s};
        K_SLTU:       result = {{(W-1){1'b0}}, lt_u};
        K_SHL, K_SHR, K_SHA: result = sh_res;
        K_LUI:        result = {imm16, {(W-IMM_W){1'b0}}};
        default:      result = '0;
      endcase
    end
  end

  assign wr_idx   = ctrl.dest_rt ? rt_field : rd_field;
  assign ovf_trap = ctrl.legal & ctrl.trap & ovf;
  assign illegal  = ~ctrl.legal;
  assign wr_en    = ctrl.legal & ~ovf_trap & (wr_idx != '0);

  always_comb begin
    // R10
    flag_excl_chk: assert ($onehot0({ovf_trap, illegal}))
      else $error("trap and illegal raised together");
    // R9
    zero_dest_chk: assert (!wr_en || (wr_idx != '0))
      else $error("write enabled toward index zero");
    // R3
    cmp_width_chk: assert (!(ctrl.kind inside {K_SLT, K_SLTU}) || (result[W-1:1] == '0))
      else $error("compare result wider than one bit");
    // R5
    trap_block_chk: assert (!ovf_trap || !wr_en)
      else $error("trapping overflow still writes");
  end
endmodule

// File: tb/int_exec_unit_tb.sv
`timescale 1ns/1ps
module int_exec_unit_tb_top;
  logic clk;
  logic rst_n;
  logic [5:0]  op_code, fn_code;
  logic [4:0]  shamt, rt_field, rd_field;
  logic [31:0] src_a, src_b;
  logic [15:0] imm16;
  logic [31:0] result;
  logic        wr_en, ovf_trap, illegal;
  logic [4:0]  wr_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int_exec_unit dut_i (
    .op_code (op_code), .fn_code (fn_code), .shamt (shamt),
    .rt_field (rt_field), .rd_field (rd_field),
    .src_a (src_a), .src_b (src_b), .imm16 (imm16),
    .result (result), .wr_en (wr_en), .wr_idx (wr_idx),
    .ovf_trap (ovf_trap), .illegal (illegal)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [31:0] res;
    logic        we;
    logic [4:0]  idx;
    logic        ov;
    logic        il;
  } exp_t;

  function automatic exp_t model(input logic [5:0] op, input logic [5:0] fn,
                                 input logic [4:0] sa, input logic [4:0] rt,
                                 input logic [4:0] rd, input logic [31:0] a,
                                 input logic [31:0] b, input logic [15:0] im);
    exp_t e;
    logic [31:0] se, ze;
    logic signed [32:0] w;
    bit ok, trapping;
    e = '0; ok = 1; trapping = 0;
    se = {{16{im[15]}}, im};
    ze = {16'h0, im};
    w = '0;
    if (op == 6'h00) begin
      e.idx = rd;
      case (fn)
        6'h20, 6'h21: begin w = $signed({a[31], a}) + $signed({b[31], b}); e.res = a + b; trapping = (fn == 6'h20); end
        6'h22, 6'h23: begin w = $signed({a[31], a}) - $signed({b[31], b}); e.res = a - b; trapping = (fn == 6'h22); end
        6'h24: e.res = a & b;
        6'h25: e.res = a | b;
        6'h26: e.res = a ^ b;
        6'h27: e.res = ~(a | b);
        6'h2a: e.res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        6'h2b: e.res = (a < b) ? 32'd1 : 32'd0;
        6'h00: e.res = b << sa;
        6'h02: e.res = b >> sa;
        6'h03: e.res = $unsigned($signed(b) >>> sa);
        6'h04: e.res = b << a[4:0];
        6'h06: e.res = b >> a[4:0];
        6'h07: e.res = $unsigned($signed(b) >>> a[4:0]);
        default: ok = 0;
      endcase
    end else begin
      e.idx = rt;
      case (op)
        6'h08, 6'h09: begin w = $signed({a[31], a}) + $signed({se[31], se}); e.res = a + se; trapping = (op == 6'h08); end
        6'h0a: e.res = ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
        6'h0b: e.res = (a < se) ? 32'd1 : 32'd0;
        6'h0c: e.res = a & ze;
        6'h0d: e.res = a | ze;
        6'h0e: e.res = a ^ ze;
        6'h0f: e.res = {im, 16'h0};
        default: ok = 0;
      endcase
    end
    if (!ok) begin
      e.res = '0; e.il = 1; e.we = 0; e.ov = 0;
      e.idx = (op == 6'h00) ? rd : (op inside {[6'h08:6'h0f]} ? rt : rd);
    end else begin
      e.ov = trapping && (w[32] != w[31]);
      e.we = !e.ov && (e.idx != 5'd0);
    end
    return e;
  endfunction

  function automatic string tag_of(input logic [5:0] op, input logic [5:0] fn);
    if (op == 6'h00) begin
      if (fn inside {6'h20, 6'h22}) return "R5";
      if (fn inside {6'h21, 6'h23}) return "R1";
      if (fn inside {[6'h24:6'h27]}) return "R2";
      if (fn inside {6'h2a, 6'h2b}) return "R3";
      if (fn inside {6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07}) return "R4";
      return "R10";
    end
    if (op == 6'h0f) return "R7";
    if (op inside {[6'h08:6'h0e]}) return "R6";
    return "R10";
  endfunction

  task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic [4:0] sa,
                       input logic [4:0] rt, input logic [4:0] rd, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im, input string tag);
    exp_t e;
    @(negedge clk);
    op_code = op; fn_code = fn; shamt = sa; rt_field = rt; rd_field = rd;
    src_a = a; src_b = b; imm16 = im;
    e = model(op, fn, sa, rt, rd, a, b, im);
    #1;
    n_chk++;
    if (result !== e.res || wr_en !== e.we || wr_idx !== e.idx ||
        ovf_trap !== e.ov || illegal !== e.il) begin
      n_bad++;
      $display("FAIL %s op=%02h fn=%02h: got res=%08h we=%0b idx=%0d ov=%0b il=%0b, expected res=%08h we=%0b idx=%0d ov=%0b il=%0b",
               tag, op, fn, result, wr_en, wr_idx, ovf_trap, illegal,
               e.res, e.we, e.idx, e.ov, e.il);
    end
  endtask

  function automatic logic [31:0] pick_val(input int unsigned r);
    case (r % 8)
      0: return 32'h7fffffff;
      1: return 32'h80000000;
      2: return 32'hffffffff;
      3: return 32'h00000001;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    int unsigned seed_junk;
    seed_junk = $urandom(32'h5eed_1234);
    rst_n = 1'b0;
    op_code = '0; fn_code = '0; shamt = '0; rt_field = '0; rd_field = '0;
    src_a = '0; src_b = '0; imm16 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R9 quiescent state: all-zero fields target index 0, no write
    apply(6'h00, 6'h00, 5'd0, 5'd0, 5'd0, 32'h0, 32'h0, 16'h0, "R9");
    // R1 wrapping add/sub
    apply(6'h00, 6'h21, 5'd0, 5'd0, 5'd3, 32'h7fffffff, 32'h1, 16'h0, "R1");
    apply(6'h00, 6'h23, 5'd0, 5'd0, 5'd3, 32'h80000000, 32'h1, 16'h0, "R1");
    // R2 logic examples
    apply(6'h00, 6'h24, 5'd0, 5'd0, 5'd4, 32'habcd1234, 32'hffff0000, 16'h0, "R2");
    apply(6'h00, 6'h27, 5'd0, 5'd0, 5'd4, 32'habcd1234, 32'hffff0000, 16'h0, "R2");
    // R3 signed/unsigned disagree
    apply(6'h00, 6'h2a, 5'd0, 5'd0, 5'd8, 32'h1, 32'hffffffff, 16'h0, "R3");
    apply(6'h00, 6'h2b, 5'd0, 5'd0, 5'd8, 32'h1, 32'hffffffff, 16'h0, "R3");
    apply(6'h0a, 6'h00, 5'd0, 5'd9, 5'd0, 32'hfffffffe, 32'h0, 16'hffff, "R3");
    // R4 shifts
    apply(6'h00, 6'h03, 5'd4, 5'd0, 5'd5, 32'h0, 32'habcd1234, 16'h0, "R4");
    apply(6'h00, 6'h07, 5'd0, 5'd0, 5'd5, 32'hffffffe4, 32'habcd1234, 16'h0, "R4");
    apply(6'h00, 6'h04, 5'd0, 5'd0, 5'd5, 32'h0000001f, 32'h00000003, 16'h0, "R4");
    // R5 trapping overflow
    apply(6'h00, 6'h20, 5'd0, 5'd0, 5'd6, 32'h7fffffff, 32'h1, 16'h0, "R5");
    apply(6'h00, 6'h22, 5'd0, 5'd0, 5'd6, 32'h80000000, 32'h1, 16'h0, "R5");
    apply(6'h08, 6'h00, 5'd0, 5'd7, 5'd0, 32'h7fffffff, 32'h0, 16'h0001, "R5");
    apply(6'h09, 6'h00, 5'd0, 5'd7, 5'd0, 32'h7fffffff, 32'h0, 16'h0001, "R5");
    // R5 with R9: trap and zero destination in the same evaluation
    apply(6'h00, 6'h20, 5'd0, 5'd0, 5'd0, 32'h80000000, 32'h80000000, 16'h0, "R5");
    // R6 extension rules
    apply(6'h09, 6'h00, 5'd0, 5'd2, 5'd0, 32'h5, 32'h0, 16'hffff, "R6");
    apply(6'h0c, 6'h00, 5'd0, 5'd2, 5'd0, 32'hffffffff, 32'h0, 16'h8000, "R6");
    apply(6'h0b, 6'h00, 5'd0, 5'd2, 5'd0, 32'h7fffffff, 32'h0, 16'h8000, "R6");
    // R7 load upper
    apply(6'h0f, 6'h00, 5'd0, 5'd17, 5'd0, 32'hdeadbeef, 32'h0, 16'hac51, "R7");
    // R8 destination select: rd ignored for immediates, rt ignored for registers
    apply(6'h0d, 6'h00, 5'd0, 5'd12, 5'd21, 32'h0, 32'h0, 16'h65d9, "R8");
    apply(6'h00, 6'h25, 5'd0, 5'd12, 5'd21, 32'h1, 32'h2, 16'h0, "R8");
    // R9 immediate into index zero
    apply(6'h0d, 6'h00, 5'd0, 5'd0, 5'd9, 32'h0, 32'h0, 16'h1, "R9");
    // R10 illegal encodings
    apply(6'h3f, 6'h00, 5'd0, 5'd3, 5'd3, 32'h7fffffff, 32'h1, 16'h1, "R10");
    apply(6'h00, 6'h01, 5'd0, 5'd3, 5'd3, 32'h7fffffff, 32'h1, 16'h1, "R10");
    apply(6'h00, 6'h05, 5'd0, 5'd3, 5'd3, 32'h1, 32'h1, 16'h1, "R10");

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] op, fn;
      int unsigned r;
      r = $urandom % 20;
      op = 6'h00;
      fn = 6'h00;
      if (r < 10) begin
        case ($urandom % 16)
          0: fn = 6'h20;  1: fn = 6'h21;  2: fn = 6'h22;  3: fn = 6'h23;
          4: fn = 6'h24;  5: fn = 6'h25;  6: fn = 6'h26;  7: fn = 6'h27;
          8: fn = 6'h2a;  9: fn = 6'h2b;  10: fn = 6'h00; 11: fn = 6'h02;
          12: fn = 6'h03; 13: fn = 6'h04; 14: fn = 6'h06; default: fn = 6'h07;
        endcase
      end else if (r < 18) begin
        op = 6'h08 + 6'($urandom % 8);
      end else begin
        op = 6'($urandom);
        fn = 6'($urandom);
      end
      apply(op, fn, 5'($urandom), 5'($urandom), 5'($urandom),
            pick_val($urandom), pick_val($urandom), 16'($urandom),
            tag_of(op, fn));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule